// File: doc/BRIEF.md
# Target Command-Phase Length Resolver

This block sits in the target-role path of a SCSI block-move sequencer. When a move instruction is issued, it first checks that the controller is connected as a target. If so, it drives the three bus phase outputs (message, control/data, input/output) from the instruction's phase field for as long as the move lasts. A start issued while the controller is not in the target role is refused and flagged.

In command phase, the block waits for the first command byte and settles the number of bytes to transfer from that byte's group code. Standard groups replace the programmed count with the fixed command-block length. Vendor-unique groups, and all groups when the override bit is set, keep the programmed count. The two remaining groups also keep the programmed count, but a zero count there is trapped as an illegal instruction.

During a move, an attention request or a parity error raises a sticky halt request. A per-instruction defer control selects whether the move is cut off at once or the halt is raised when the move ends. Bus handshake timing, address generation and instruction fetch are handled elsewhere.

Top module: `tcl_resolver`

## Requirements
- R1: A start while `role_target_i` is low leaves the block idle (`active_o` low, phase outputs low) and pulses `role_err_o` for one cycle after the start cycle.
- R2: While a move is active, `{msg_o, cd_o, io_o}` equal `{phase_i[2], phase_i[1], phase_i[0]}` as latched at start. While idle, all three are low. Command phase is encoded as 3'b010.
- R3: In command phase with `ovr_i` clear, the group code (bits 7:5 of the first command byte) selects the count: group 0 gives 6, groups 1 and 2 give 10, and group 5 gives 12.
- R4: In command phase with `ovr_i` set, the resolved count equals the programmed `count_i` for every group code.
- R5: In command phase with `ovr_i` clear, groups 6 and 7 resolve to the programmed count.
- R6: In command phase with `ovr_i` clear, groups 3 and 4 resolve to the programmed count. If that count is zero, `illegal_o` pulses together with `cnt_valid_o` and the block returns to idle.
- R7: For a phase other than command, `cnt_valid_o` pulses in the cycle after the start cycle, with `cnt_o` equal to `count_i`.
- R8: In command phase, `cnt_valid_o` is high for exactly one cycle, starting the cycle after the first command byte is accepted (`cmd_valid_i` high while waiting).
- R9: With defer clear at start, `atn_i` or `par_err_i` during an active move sets `halt_o` in the next cycle and ends the move at once.
- R10: With defer set at start, an attention or parity event does not end the move. `halt_o` rises in the cycle after the move ends.
- R11: `halt_o` stays set until `halt_clr_i`. When a new halt event and a clear arrive in the same cycle, the halt stays set.
- R12: A start while a move is active is ignored, and the latched phase does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| role_target_i | input | 1 | Controller is connected as target |
| start_i | input | 1 | Issue a move instruction |
| phase_i | input | 3 | Instruction phase field {MSG, C/D, I/O} |
| count_i | input | CNT_W | Programmed byte count |
| ovr_i | input | 1 | Vendor-unique override: keep programmed count |
| defer_i | input | 1 | Defer halt until the move ends |
| cmd_valid_i | input | 1 | First command byte present |
| cmd_byte_i | input | 8 | First command byte |
| atn_i | input | 1 | Attention from initiator |
| par_err_i | input | 1 | Parity error seen |
| move_done_i | input | 1 | Current move has finished |
| halt_clr_i | input | 1 | Software clear of the halt request |
| msg_o | output | 1 | MSG phase output |
| cd_o | output | 1 | C/D phase output |
| io_o | output | 1 | I/O phase output |
| active_o | output | 1 | Move in progress |
| cnt_valid_o | output | 1 | Resolved count valid pulse |
| cnt_o | output | CNT_W | Resolved byte count |
| illegal_o | output | 1 | Illegal-instruction pulse |
| role_err_o | output | 1 | Start refused: not in target role |
| halt_o | output | 1 | Sticky halt request |

## Verification
The bench sweeps all eight group codes with the override set and clear, and uses zero counts in groups 3 and 4. A resolver that traps zero in the wrong groups, or that ignores the override, would report a wrong count or a false illegal pulse. Halt handling is checked in both modes. An immediate halt that waits, or a deferred halt that cuts the move short, shows up in `halt_o` or `active_o` on the wrong cycle. A clear that beats a simultaneous new event loses the halt, and a start during a move corrupts the phase outputs.

// File: rtl/tcl_pkg.sv
// Package: shared state type, phase encoding and group-length lookup
// for the target command-phase length resolver.
// Assumes: group code sits in bits 7:5 of the first command byte.
package tcl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_CMD = 2'd1,
        ST_MOVE     = 2'd2
    } tcl_state_t;

    // {MSG, C/D, I/O} value for command phase
    localparam logic [2:0] PH_COMMAND = 3'b010;

    // Kind of group: fixed length, vendor unique, or other
    typedef enum logic [1:0] {
        GK_FIXED  = 2'd0,
        GK_VENDOR = 2'd1,
        GK_OTHER  = 2'd2
    } tcl_gkind_t;

    // Classify a 3-bit group code
    function automatic tcl_gkind_t group_kind(input logic [2:0] grp);
        case (grp)
            3'd0, 3'd1, 3'd2, 3'd5: group_kind = GK_FIXED;
            3'd6, 3'd7:             group_kind = GK_VENDOR;
            default:                group_kind = GK_OTHER;
        endcase
    endfunction

    // Command-block length for fixed-length groups
    function automatic logic [3:0] group_len(input logic [2:0] grp);
        case (grp)
            3'd0:       group_len = 4'd6;
            3'd1, 3'd2: group_len = 4'd10;
            3'd5:       group_len = 4'd12;
            default:    group_len = 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/tcl_len_resolve.sv
// Module: combinational count resolver.
// Takes the group code of the first command byte, the override bit and the
// programmed count; returns the count to transfer and an illegal flag.
// Assumes: CNT_W >= 4 so every fixed length fits.
module tcl_len_resolve #(
    parameter int CNT_W = 24
) (
    input  logic [2:0]       grp_i,
    input  logic             ovr_i,
    input  logic [CNT_W-1:0] prog_i,
    output logic [CNT_W-1:0] len_o,
    output logic             illegal_o
);
    import tcl_pkg::*;

    localparam int PAD_W = CNT_W - 4;

    tcl_gkind_t kind;

    // Pick resolved count and illegal flag from group kind and override
    always_comb begin
        kind      = group_kind(grp_i);
        len_o     = prog_i;
        illegal_o = 1'b0;
        if (!ovr_i) begin
            case (kind)
                GK_FIXED:  len_o = {{PAD_W{1'b0}}, group_len(grp_i)};
                GK_OTHER:  illegal_o = (prog_i == '0);
                default:   len_o = prog_i;
            endcase
        end
    end

endmodule

// File: rtl/tcl_phase_drv.sv
// Module: phase output register.
// Loads the instruction phase field at move start and clears it when the
// move ends, so the bus phase lines are low whenever no move is active.
module tcl_phase_drv (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       clear_i,
    input  logic [2:0] phase_i,
    output logic       msg_o,
    output logic       cd_o,
    output logic       io_o,
    output logic [2:0] phase_q_o
);
    logic [2:0] ph_q;

    // Hold the driven phase for the life of a move
    always_ff @(posedge clk) begin
        if (!rst_n)        ph_q <= 3'b000;
        else if (load_i)   ph_q <= phase_i;
        else if (clear_i)  ph_q <= 3'b000;
    end

    assign msg_o     = ph_q[2];
    assign cd_o      = ph_q[1];
    assign io_o      = ph_q[0];
    assign phase_q_o = ph_q;

endmodule

// File: rtl/tcl_halt_trk.sv
// Module: sticky halt tracker.
// Immediate mode: an event while active sets the halt at once.
// Deferred mode: events are remembered and the halt is set when the move
// ends. A set always wins over a software clear in the same cycle.
module tcl_halt_trk (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic defer_i,
    input  logic evt_i,
    input  logic end_i,
    input  logic clr_i,
    output logic halt_o
);
    logic pend_q;
    logic halt_q;
    logic set_now;

    // Decide whether the halt is raised this cycle
    always_comb begin
        set_now = 1'b0;
        if (active_i && evt_i && !defer_i)            set_now = 1'b1;
        if (end_i && defer_i && (pend_q || evt_i))    set_now = 1'b1;
    end

    // Remember deferred events until the move ends
    always_ff @(posedge clk) begin
        if (!rst_n)                                pend_q <= 1'b0;
        else if (end_i || !active_i)               pend_q <= 1'b0;
        else if (evt_i && defer_i)                 pend_q <= 1'b1;
    end

    // Sticky halt flag, set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n)        halt_q <= 1'b0;
        else if (set_now)  halt_q <= 1'b1;
        else if (clr_i)    halt_q <= 1'b0;
    end

    assign halt_o = halt_q;

endmodule

// File: rtl/tcl_resolver.sv
// Module: top of the target command-phase length resolver.
// Sequences a block move in target role: role check, phase drive, count
// resolution from the first command byte, illegal trap and halt control.
// Assumes: move_done_i comes from the transfer engine once the count is
// used up; cmd_valid_i is only looked at while waiting for the first byte.
module tcl_resolver #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             role_target_i,
    input  logic             start_i,
    input  logic [2:0]       phase_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             ovr_i,
    input  logic             defer_i,
    input  logic             cmd_valid_i,
    input  logic [7:0]       cmd_byte_i,
    input  logic             atn_i,
    input  logic             par_err_i,
    input  logic             move_done_i,
    input  logic             halt_clr_i,
    output logic             msg_o,
    output logic             cd_o,
    output logic             io_o,
    output logic             active_o,
    output logic             cnt_valid_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             illegal_o,
    output logic             role_err_o,
    output logic             halt_o
);
    import tcl_pkg::*;

    localparam int GRP_LSB = 5;

    tcl_state_t       state_q, state_d;
    logic [CNT_W-1:0] prog_q;
    logic             ovr_q;
    logic             defer_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             vld_q, vld_d;
    logic             ill_q, ill_d;
    logic             rerr_q, rerr_d;
    logic             load_ph;
    logic             active;
    logic             evt;
    logic             abort;
    logic             move_end;
    logic [CNT_W-1:0] res_len;
    logic             res_ill;
    logic [2:0]       phase_q;

    assign active   = (state_q != ST_IDLE);
    assign evt      = atn_i | par_err_i;
    assign abort    = active && evt && !defer_q;
    assign move_end = active && (state_d == ST_IDLE);

    tcl_len_resolve #(.CNT_W(CNT_W)) u_len (
        .grp_i     (cmd_byte_i[GRP_LSB +: 3]),
        .ovr_i     (ovr_q),
        .prog_i    (prog_q),
        .len_o     (res_len),
        .illegal_o (res_ill)
    );

    tcl_phase_drv u_ph (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_ph),
        .clear_i   (move_end),
        .phase_i   (phase_i),
        .msg_o     (msg_o),
        .cd_o      (cd_o),
        .io_o      (io_o),
        .phase_q_o (phase_q)
    );

    tcl_halt_trk u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .defer_i  (defer_q),
        .evt_i    (evt),
        .end_i    (move_end),
        .clr_i    (halt_clr_i),
        .halt_o   (halt_o)
    );

    // Next-state and result selection for one move
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        vld_d   = 1'b0;
        ill_d   = 1'b0;
        rerr_d  = 1'b0;
        load_ph = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (!role_target_i) begin
                        rerr_d = 1'b1;
                    end else begin
                        load_ph = 1'b1;
                        if (phase_i == PH_COMMAND) begin
                            state_d = ST_WAIT_CMD;
                        end else begin
                            state_d = ST_MOVE;
                            vld_d   = 1'b1;
                            cnt_d   = count_i;
                        end
                    end
                end
            end
            ST_WAIT_CMD: begin
                if (abort) begin
                    state_d = ST_IDLE;
                end else if (cmd_valid_i) begin
                    vld_d   = 1'b1;
                    ill_d   = res_ill;
                    cnt_d   = res_len;
                    state_d = res_ill ? ST_IDLE : ST_MOVE;
                end
            end
            ST_MOVE: begin
                if (abort || move_done_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            vld_q   <= 1'b0;
            ill_q   <= 1'b0;
            rerr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            vld_q   <= vld_d;
            ill_q   <= ill_d;
            rerr_q  <= rerr_d;
        end
    end

    // Instruction fields captured at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_q  <= '0;
            ovr_q   <= 1'b0;
            defer_q <= 1'b0;
        end else if (load_ph) begin
            prog_q  <= count_i;
            ovr_q   <= ovr_i;
            defer_q <= defer_i;
        end
    end

    assign active_o    = active;
    assign cnt_valid_o = vld_q;
    assign cnt_o       = cnt_q;
    assign illegal_o   = ill_q;
    assign role_err_o  = rerr_q;

endmodule

// File: rtl/tcl_resolver_chk.sv
// Module: property checker for tcl_resolver, attached by bind below.
module tcl_resolver_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             role_target_i,
    input logic             start_i,
    input logic             halt_clr_i,
    input logic             msg_o,
    input logic             cd_o,
    input logic             io_o,
    input logic             active_o,
    input logic             cnt_valid_o,
    input logic [CNT_W-1:0] cnt_o,
    input logic             illegal_o,
    input logic             role_err_o,
    input logic             halt_o
);
    AST_IDLE_PHASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> !(msg_o || cd_o || io_o));   // R2

    AST_ROLE_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !active_o && !role_target_i) |=> (role_err_o && !active_o));   // R1

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_valid_o |=> !cnt_valid_o);   // R8

    AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (cnt_valid_o && !active_o && cnt_o == '0));   // R6

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && !halt_clr_i) |=> halt_o);   // R11

endmodule

bind tcl_resolver tcl_resolver_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .role_target_i (role_target_i),
    .start_i       (start_i),
    .halt_clr_i    (halt_clr_i),
    .msg_o         (msg_o),
    .cd_o          (cd_o),
    .io_o          (io_o),
    .active_o      (active_o),
    .cnt_valid_o   (cnt_valid_o),
    .cnt_o         (cnt_o),
    .illegal_o     (illegal_o),
    .role_err_o    (role_err_o),
    .halt_o        (halt_o)
);

// File: tb/tcl_resolver_tb.sv
module tcl_resolver_tb;
    localparam int CNT_W = 24;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             role_target_i, start_i, ovr_i, defer_i;
    logic [2:0]       phase_i;
    logic [CNT_W-1:0] count_i;
    logic             cmd_valid_i;
    logic [7:0]       cmd_byte_i;
    logic             atn_i, par_err_i, move_done_i, halt_clr_i;
    logic             msg_o, cd_o, io_o, active_o, cnt_valid_o;
    logic [CNT_W-1:0] cnt_o;
    logic             illegal_o, role_err_o, halt_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tcl_resolver #(.CNT_W(CNT_W)) u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Bench model of the count rule
    function automatic logic [CNT_W-1:0] exp_cnt(input logic [7:0] b, input logic ov,
                                                 input logic [CNT_W-1:0] c);
        if (ov) return c;
        case (b[7:5])
            3'd0: return 6;
            3'd1, 3'd2: return 10;
            3'd5: return 12;
            default: return c;
        endcase
    endfunction

    function automatic logic exp_ill(input logic [7:0] b, input logic ov,
                                     input logic [CNT_W-1:0] c);
        return !ov && (b[7:5] == 3'd3 || b[7:5] == 3'd4) && c == 0;
    endfunction

    task automatic idle_inputs();
        start_i = 0; cmd_valid_i = 0; atn_i = 0; par_err_i = 0;
        move_done_i = 0; halt_clr_i = 0;
    endtask

    // One command-phase move with full checking
    task automatic cmd_move(input logic [7:0] b, input logic ov, input logic [CNT_W-1:0] c,
                            input string tag);
        logic [CNT_W-1:0] ec;
        logic ei;
        ec = exp_ill(b, ov, c) ? '0 : exp_cnt(b, ov, c);
        ei = exp_ill(b, ov, c);
        start_i = 1; phase_i = 3'b010; count_i = c; ovr_i = ov; defer_i = 0;
        @(negedge clk); start_i = 0;
        chk("R2 cmd phase", {29'd0, msg_o, cd_o, io_o}, 32'b010);
        chk("R8 no early valid", cnt_valid_o, 0);
        cmd_valid_i = 1; cmd_byte_i = b;
        @(negedge clk); cmd_valid_i = 0;
        chk({tag, " valid"}, cnt_valid_o, 1);
        chk({tag, " count"}, cnt_o, ec);
        chk({tag, " R6 illegal"}, illegal_o, ei);
        @(negedge clk);
        chk("R8 single pulse", cnt_valid_o, 0);
        if (!ei) begin
            move_done_i = 1;
            @(negedge clk); move_done_i = 0;
        end
        chk({tag, " idle"}, active_o, 0);
    endtask

    initial begin
        int seed;
        seed = 32'h5A17;
        void'($urandom(seed));
        rst_n = 0; role_target_i = 1; phase_i = 0; count_i = 0; ovr_i = 0;
        defer_i = 0; cmd_byte_i = 0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("reset active", active_o, 0);
        chk("reset halt", halt_o, 0);
        chk("reset valid", cnt_valid_o, 0);
        chk("R2 idle phase", {29'd0, msg_o, cd_o, io_o}, 0);

        // R1 role refusal
        role_target_i = 0; start_i = 1; phase_i = 3'b001; count_i = 7;
        @(negedge clk); start_i = 0;
        chk("R1 role_err", role_err_o, 1);
        chk("R1 stays idle", active_o, 0);
        chk("R1 no phase", {29'd0, msg_o, cd_o, io_o}, 0);
        role_target_i = 1;
        @(negedge clk);

        // R3 R4 R5 R6 directed sweep
        for (int g = 0; g < 8; g++) begin
            cmd_move({g[2:0], 5'd3}, 0, 24'd33, "R3 R5 R6 ovr clear");
            cmd_move({g[2:0], 5'd1}, 1, 24'd77, "R4 ovr set");
        end
        cmd_move(8'h60, 0, 0, "R6 grp3 zero");
        cmd_move(8'h80, 0, 0, "R6 grp4 zero");
        cmd_move(8'hE0, 0, 0, "R5 grp7 zero");
        cmd_move(8'h60, 1, 0, "R4 grp3 zero ovr");

        // R7 non-command phase, R2 phase drive, R12 start ignored
        start_i = 1; phase_i = 3'b001; count_i = 24'd500; defer_i = 0;
        @(negedge clk); start_i = 0;
        chk("R7 valid", cnt_valid_o, 1);
        chk("R7 count", cnt_o, 500);
        chk("R2 data phase", {29'd0, msg_o, cd_o, io_o}, 3'b001);
        start_i = 1; phase_i = 3'b111;
        @(negedge clk); start_i = 0;
        chk("R12 phase kept", {29'd0, msg_o, cd_o, io_o}, 3'b001);
        chk("R12 no valid", cnt_valid_o, 0);

        // R9 immediate halt
        atn_i = 1;
        @(negedge clk); atn_i = 0;
        chk("R9 halt", halt_o, 1);
        chk("R9 move ended", active_o, 0);
        repeat (3) @(negedge clk);
        chk("R11 sticky", halt_o, 1);
        halt_clr_i = 1;
        @(negedge clk); halt_clr_i = 0;
        chk("R11 cleared", halt_o, 0);

        // R10 deferred halt
        start_i = 1; phase_i = 3'b000; count_i = 24'd9; defer_i = 1;
        @(negedge clk); start_i = 0;
        par_err_i = 1;
        @(negedge clk); par_err_i = 0;
        chk("R10 no early halt", halt_o, 0);
        chk("R10 still active", active_o, 1);
        move_done_i = 1;
        @(negedge clk); move_done_i = 0;
        chk("R10 halt at end", halt_o, 1);
        chk("R10 idle", active_o, 0);
        halt_clr_i = 1;
        @(negedge clk); halt_clr_i = 0;

        // R11 set beats clear
        start_i = 1; phase_i = 3'b011; defer_i = 0;
        @(negedge clk); start_i = 0;
        atn_i = 1; halt_clr_i = 1;
        @(negedge clk); atn_i = 0; halt_clr_i = 0;
        chk("R11 set wins", halt_o, 1);
        halt_clr_i = 1;
        @(negedge clk); halt_clr_i = 0;
        chk("R11 clear", halt_o, 0);

        // Random command moves
        for (int i = 0; i < 300; i++) begin
            logic [7:0] b;
            logic ov;
            logic [CNT_W-1:0] c;
            b  = 8'($urandom);
            ov = 1'($urandom);
            c  = ($urandom % 4 == 0) ? '0 : CNT_W'($urandom % 4096);
            cmd_move(b, ov, c, "R3 R4 R5 R6 random");
        end

        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule